// File: doc/BRIEF.md
# Biphase-Mark Sub-Frame Line Encoder

This block turns a stream of sub-frame words into one biphase-mark coded serial line. Each word arrives as a 2-bit sync-pattern selector and a 28-bit payload. The payload is the audio sample, the validity, user and channel-status flags, and the parity bit, already put together upstream. For each word the encoder sends 64 line states. The first 8 states are a sync pattern that deliberately breaks the coding rule, so that a receiver can find the sub-frame boundary. The other 56 states code the 28 payload bits in biphase-mark form.

A single-cycle state-rate enable paces the line. A clock divider outside the block produces it at 64 states per sub-frame, or 128 per stereo frame. Words come in through a valid/ready handshake. Ready is offered only on the enable that follows the last state of the current word. If no word is waiting at that moment, the line holds its level and a starvation flag rises until a word is taken again. Each sync pattern is sent in its plain or its inverted form, chosen by the line level just before it, so that the stream has no DC bias.

Top module: `bmc_line_encoder`

## Requirements
- R1: While reset is held and after reset is released, `lineOut` is 0, `underrun` is 0 and `inReady` is 0 until the first enable.
- R2: Sync selector codes are 0 for block start, 1 for left channel, 2 for right channel, and 3, which is treated as left channel. If the line was 0 before the pattern, the 8 states, first to last, are 11101000, 11100010 and 11100100 for these three types.
- R3: If the line was 1 before the sync pattern, the bitwise inverse of the R2 pattern is sent (00010111, 00011101, 00011011).
- R4: After the sync pattern, payload bits go out from bit 0 up to bit 27. Each bit takes two states, and the first state is the inverse of the state before it.
- R5: For a payload bit of 0, the second state equals the first. For a payload bit of 1, the second state is the inverse of the first.
- R6: `lineOut` changes only on a clock edge where `stateEn` is high. Each word produces exactly 64 states.
- R7: `inReady` is high only together with `stateEn`, and only when the encoder is idle or has just sent state 64 of the current word. A word is taken when `inValid` and `inReady` are both high, and its first sync state appears on that same edge.
- R8: If no word is offered at a load point, `lineOut` holds its level and `underrun` goes to 1 and stays there until a word is taken. Taking a word clears it.
- R9: After an idle gap, the next sync pattern is chosen by the level that was held during the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateEn | input | 1 | One-cycle pulse at the line-state rate |
| inValid | input | 1 | A word is offered |
| inReady | output | 1 | The word is taken on this edge if inValid is high |
| inPre | input | 2 | Sync pattern selector (0 block, 1 left, 2 right, 3 left) |
| inPayload | input | 28 | Sub-frame bits 4..31, bit 0 sent first |
| lineOut | output | 1 | Coded line |
| underrun | output | 1 | No word was available at the last load point |

## Verification
The bench keeps a separate line-level model and sends payloads with an odd number of zeros. Those payloads leave the line at 1 at the end of a sub-frame, so the inverted sync patterns get exercised. A design that ignored the preceding level would then send a plain pattern and lose DC balance at every other boundary. Idle gaps between words check that the line holds, that `underrun` rises, and that the pattern after a gap follows the held level. A design that kept toggling during the gap, or reset its level there, would produce the wrong sync polarity. Bit order is checked with asymmetric payloads, which would show up a reversed shift direction. The code-3 selector and the three sync types at both polarities are each compared state by state.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int STATES_PER_SUB = 64;
  localparam int SYNC_STATES    = 8;
  localparam int PAYLOAD_BITS   = (STATES_PER_SUB - SYNC_STATES) / 2;
  localparam int CNT_W          = $clog2(STATES_PER_SUB);
  localparam int SYNC_IDX_W     = $clog2(SYNC_STATES);

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_LEFT  = 2'd1,
    SYNC_RIGHT = 2'd2,
    SYNC_ALT   = 2'd3
  } syncSel_e;

  typedef struct packed {
    logic                  load;
    logic                  syncStep;
    logic [SYNC_IDX_W-1:0] syncIdx;
    logic                  dataFirst;
    logic                  dataSecond;
  } encStrobe_t;

  // Pattern for a preceding line level of 0, MSB is the first state.
  function automatic logic [SYNC_STATES-1:0] syncPattern(input logic [1:0] sel);
    case (sel)
      SYNC_BLOCK: syncPattern = 8'b1110_1000;
      SYNC_RIGHT: syncPattern = 8'b1110_0100;
      default:    syncPattern = 8'b1110_0010;
    endcase
  endfunction
endpackage

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
  import bmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stateEn,
  input  logic       inValid,
  output logic       inReady,
  output logic       underrun,
  output encStrobe_t strb
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(STATES_PER_SUB - 1);

  logic             active;
  logic [CNT_W-1:0] stateCnt;
  logic [CNT_W-1:0] nextIdx;
  logic             needWord;
  logic             stepping;

  assign needWord = !active || (stateCnt == LAST_IDX);
  assign inReady  = stateEn && needWord;
  assign stepping = stateEn && !needWord;
  assign nextIdx  = stateCnt + 1'b1;

  always_comb begin
    strb            = '0;
    strb.load       = inReady && inValid;
    strb.syncStep   = stepping && (nextIdx < CNT_W'(SYNC_STATES));
    strb.syncIdx    = nextIdx[SYNC_IDX_W-1:0];
    strb.dataFirst  = stepping && (nextIdx >= CNT_W'(SYNC_STATES)) && !nextIdx[0];
    strb.dataSecond = stepping && (nextIdx >= CNT_W'(SYNC_STATES)) &&  nextIdx[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      stateCnt <= '0;
      underrun <= 1'b0;
    end else if (stateEn) begin
      if (needWord) begin
        stateCnt <= '0;
        active   <= inValid;
        underrun <= !inValid;
      end else begin
        stateCnt <= nextIdx;
      end
    end
  end

  AST_READY_ON_EN: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> stateEn);  // R7
  AST_STARVE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> underrun);  // R8
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |=> !underrun);  // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.syncStep, strb.dataFirst, strb.dataSecond}));  // R6
endmodule

// File: rtl/bmc_datapath.sv
module bmc_datapath
  import bmc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  encStrobe_t              strb,
  input  logic [1:0]              inPre,
  input  logic [PAYLOAD_BITS-1:0] inPayload,
  output logic                    lineOut
);
  logic [SYNC_STATES-1:0]  syncBits;
  logic [SYNC_STATES-1:0]  loadPattern;
  logic [PAYLOAD_BITS-1:0] shiftReg;

  assign loadPattern = syncPattern(inPre) ^ {SYNC_STATES{lineOut}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOut  <= 1'b0;
      syncBits <= '0;
      shiftReg <= '0;
    end else if (strb.load) begin
      syncBits <= loadPattern;
      lineOut  <= loadPattern[SYNC_STATES-1];
      shiftReg <= inPayload;
    end else if (strb.syncStep) begin
      lineOut  <= syncBits[SYNC_IDX_W'(SYNC_STATES - 1) - strb.syncIdx];
    end else if (strb.dataFirst) begin
      lineOut  <= !lineOut;
    end else if (strb.dataSecond) begin
      lineOut  <= shiftReg[0] ? !lineOut : lineOut;
      shiftReg <= shiftReg >> 1;
    end
  end

  AST_FIRST_HALF_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataFirst |=> (lineOut != $past(lineOut)));  // R4
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.syncStep || strb.dataFirst || strb.dataSecond) |=> $stable(lineOut));  // R6
  AST_SYNC_STARTS_INVERTED: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (lineOut != $past(lineOut)));  // R3
endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
  import bmc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stateEn,
  input  logic        inValid,
  output logic        inReady,
  input  logic [1:0]  inPre,
  input  logic [27:0] inPayload,
  output logic        lineOut,
  output logic        underrun
);
  encStrobe_t strb;

  bmc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stateEn  (stateEn),
    .inValid  (inValid),
    .inReady  (inReady),
    .underrun (underrun),
    .strb     (strb)
  );

  bmc_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inPre     (inPre),
    .inPayload (inPayload),
    .lineOut   (lineOut)
  );

  AST_LINE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stateEn |=> $stable(lineOut));  // R6
  AST_STARVED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !(inReady && inValid)) |=> $stable(lineOut));  // R8
endmodule

// File: tb/bmc_line_encoder_tb.sv
module bmc_line_encoder_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  EN_DIV     = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stateEn = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inPre = 2'd0;
  logic [27:0] inPayload = '0;
  logic        lineOut;
  logic        underrun;

  int nChecks = 0;
  int nFails  = 0;
  logic expQ[$];
  logic modelLvl = 1'b0;
  logic lastExp  = 1'b0;
  logic enSeen   = 1'b0;
  logic runEn    = 1'b0;

  bmc_line_encoder u_dut (
    .clk(clk), .rstN(rstN), .stateEn(stateEn), .inValid(inValid),
    .inReady(inReady), .inPre(inPre), .inPayload(inPayload),
    .lineOut(lineOut), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // State-rate enable generator
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (runEn) begin
        stateEn <= (k == EN_DIV - 1);
        k = (k == EN_DIV - 1) ? 0 : k + 1;
      end else stateEn <= 1'b0;
    end
  end

  always @(posedge clk) enSeen = stateEn;

  // Monitor: pops expected states at every enable, checks holds otherwise
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && runEn) begin
        if (enSeen) begin
          if (expQ.size() > 0) begin
            lastExp = expQ.pop_front();
            check("R2/R3/R4/R5 state", lineOut, lastExp);
            check("R8 underrun clear", underrun, 1'b0);
          end else begin
            check("R8/R9 hold while starved", lineOut, lastExp);
            check("R8 underrun set", underrun, 1'b1);
          end
        end else begin
          check("R6 stable between enables", lineOut, lastExp);
        end
      end
    end
  end

  function automatic logic [7:0] pat(input logic [1:0] sel);
    case (sel)
      2'd0: pat = 8'b1110_1000;
      2'd2: pat = 8'b1110_0100;
      default: pat = 8'b1110_0010;  // codes 1 and 3 (R2)
    endcase
  endfunction

  task automatic pushExpected(input logic [1:0] sel, input logic [27:0] pl);
    logic [7:0] p = pat(sel) ^ {8{modelLvl}};
    for (int i = 7; i >= 0; i--) begin
      modelLvl = p[i];
      expQ.push_back(modelLvl);
    end
    for (int j = 0; j < 28; j++) begin
      modelLvl = ~modelLvl;
      expQ.push_back(modelLvl);
      if (pl[j]) modelLvl = ~modelLvl;
      expQ.push_back(modelLvl);
    end
  endtask

  // Driver: offers a word, pushes its 64 expected states once taken
  task automatic sendWord(input logic [1:0] sel, input logic [27:0] pl);
    @(negedge clk);
    inValid   <= 1'b1;
    inPre     <= sel;
    inPayload <= pl;
    forever begin
      #1;
      if (inReady) begin
        check("R7 ready only with enable", stateEn, 1'b1);
        @(posedge clk);
        pushExpected(sel, pl);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    inValid <= 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 line in reset", lineOut, 1'b0);
    check("R1 underrun in reset", underrun, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 line after reset", lineOut, 1'b0);
    check("R1 ready idle without enable", inReady, 1'b0);
    runEn = 1'b1;

    // First word from level 0, block sync (R2)
    sendWord(2'd0, 28'h0000001);        // 27 zeros -> odd, ends at 1
    sendWord(2'd2, 28'h0F0F0F0);        // right sync, inverted (R3)
    sendWord(2'd1, 28'hFFFFFFF);        // all ones (R5)
    sendWord(2'd3, 28'h5555555);        // code 3 -> left (R2)
    sendWord(2'd0, 28'h0000000);        // all zeros (R4)
    sendWord(2'd1, 28'h8000000);        // bit order asymmetric (R4)
    sendWord(2'd2, 28'h0000003);
    waitDrain();
    repeat (EN_DIV * 5) @(negedge clk);  // idle gap, underrun (R8)
    sendWord(2'd1, 28'h1234567);        // sync after gap from held level (R9)
    sendWord(2'd0, 28'hABCDEF1);
    waitDrain();
    repeat (EN_DIV * 3) @(negedge clk);
    sendWord(2'd2, 28'h7FFFFFE);        // R9 second gap
    for (int w = 0; w < 6; w++)
      sendWord(2'(w), 28'(32'h9E3779B1 * (w + 1)));
    waitDrain();
    repeat (EN_DIV * 2) @(negedge clk);
    runEn = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule